// File: doc/BRIEF.md
# Dual-Mode Row Scan Shifter

This block is the logic core of a row (common) driver for a passive-matrix display. A single select token enters on whichever cascade enable pin is acting as the input. It advances one row for each line strobe through a chain of `ROWS` stages. The chain runs toward higher or lower row numbers. In dual mode it splits into two halves of `ROWS/2` stages. The first half takes the token from the cascade input. The second half takes it from a separate auxiliary input.

The stage that drives the cascade output is the last stage of the chain in single mode, or the last stage of the first half in dual mode. That stage is registered and presented on the opposite enable pin, so several devices can be chained. Every row's stage bit is combined with the frame polarity and the display-enable input. The result is a registered 2-bit level-select code per row, which the analog drivers turn into a voltage.

Top module: `row_scan_shifter`

## Requirements
- R1: While `rst` is high, both cascade outputs are 0 and every row code is 2'b11. Every chain stage is cleared.
- R2: The chain moves only on a clock edge where `line_pulse` is sampled low after being sampled high on the previous edge. Holding `line_pulse` high, or a rising transition, leaves the row codes and cascade outputs unchanged.
- R3: Single mode with `dir_up`=1: `cas_a_in` enters row 1 (code bits [1:0]), and each row passes its bit to the next higher row. `cas_b_out` presents row `ROWS`.
- R4: Single mode with `dir_up`=0: `cas_b_in` enters row `ROWS`, and bits move toward row 1. `cas_a_out` presents row 1.
- R5: Dual mode with `dir_up`=1: `cas_a_in` enters row 1 and moves up to row `ROWS/2`. `aux_in` enters row `ROWS/2+1` and moves up to row `ROWS`. `cas_b_out` presents row `ROWS/2`.
- R6: Dual mode with `dir_up`=0: `cas_b_in` enters row `ROWS/2` and moves down to row 1. `aux_in` enters row `ROWS` and moves down to row `ROWS/2+1`. `cas_a_out` presents row 1.
- R7: `cas_b_oe` equals `dir_up` and `cas_a_oe` is its inverse. The pin that is not enabled as an output reads 0.
- R8: With `blank_n`=1, a row code is {frame, bit} mapped as follows: frame 0 and bit 0 give 2'b10, frame 0 and bit 1 give 2'b00, frame 1 and bit 0 give 2'b01, frame 1 and bit 1 give 2'b11.
- R9: One clock after `blank_n` is sampled low, every row code is 2'b11, whatever the chain holds.
- R10: The row codes and cascade outputs take the new chain contents one clock after the shifting edge. On the shifting edge itself they still show the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | Line strobe; its falling edge advances the chain |
| dir_up | input | 1 | 1: scan toward higher rows, 0: toward lower rows |
| dual_mode | input | 1 | 1: two independent half chains |
| cas_a_in | input | 1 | Cascade pin A input (used when `dir_up`=1) |
| cas_b_in | input | 1 | Cascade pin B input (used when `dir_up`=0) |
| aux_in | input | 1 | Second-half token input in dual mode |
| frame | input | 1 | Frame polarity |
| blank_n | input | 1 | 0 forces all rows to code 2'b11 |
| cas_a_out | output | 1 | Cascade pin A output value |
| cas_a_oe | output | 1 | Cascade pin A output enable |
| cas_b_out | output | 1 | Cascade pin B output value |
| cas_b_oe | output | 1 | Cascade pin B output enable |
| lvl_code | output | 2*ROWS | Row codes, row r at bits [2r-1:2r-2] |

## Verification
The bench builds the shifter with `ROWS` = 8, so each half has four stages. At that size a token crosses the whole chain, or one half, within a few line strobes. The cascade output, the seam between the halves at rows 4 and 5, and both end rows are then all checked in every direction and mode. A scoreboard model follows the token pattern row by row and predicts every code and pin after each strobe.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V1 = 2'b01,
    LVL_V4 = 2'b10,
    LVL_V5 = 2'b11
  } row_lvl_e;

  // Code for one row from frame polarity, select bit and display enable.
  function automatic row_lvl_e row_level(input logic frm, input logic sel, input logic on_n);
    row_lvl_e res;
    if (!on_n) begin
      res = LVL_V5;
    end else begin
      case ({frm, sel})
        2'b00:   res = LVL_V4;
        2'b01:   res = LVL_V0;
        2'b10:   res = LVL_V1;
        default: res = LVL_V5;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/row_scan_strobe.sv
module row_scan_strobe (
  input  logic clk,
  input  logic rst,
  input  logic line_pulse,
  output logic shift
);
  logic lp_q;

  always_ff @(posedge clk) begin
    if (rst) lp_q <= 1'b0;
    else     lp_q <= line_pulse;
  end

  assign shift = lp_q & ~line_pulse;
endmodule

// File: rtl/row_scan_chain.sv
module row_scan_chain #(
  parameter int ROWS = 240
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift,
  input  logic            up,
  input  logic            dual,
  input  logic            head_in,
  input  logic            aux_in,
  output logic [ROWS-1:0] q
);
  localparam int HALF = ROWS / 2;

  logic [ROWS-1:0] nxt;

  for (genvar i = 0; i < ROWS; i++) begin : g_stage
    logic from_lo;
    logic from_hi;

    if (i == 0) begin : g_lo_head
      assign from_lo = head_in;
    end else if (i == HALF) begin : g_lo_seam
      assign from_lo = dual ? aux_in : q[i-1];
    end else begin : g_lo_mid
      assign from_lo = q[i-1];
    end

    if (i == ROWS - 1) begin : g_hi_end
      assign from_hi = dual ? aux_in : head_in;
    end else if (i == HALF - 1) begin : g_hi_seam
      assign from_hi = dual ? head_in : q[i+1];
    end else begin : g_hi_mid
      assign from_hi = q[i+1];
    end

    assign nxt[i] = up ? from_lo : from_hi;
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= nxt;
  end

  // R2
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(q));

  // R3
  head_up_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && up) |=> (q[0] == $past(head_in)));

  // R5
  aux_up_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && up && dual) |=> (q[HALF] == $past(aux_in)));

  // R6
  aux_down_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !up && dual) |=> (q[ROWS-1] == $past(aux_in)));
endmodule

// File: rtl/row_scan_levels.sv
module row_scan_levels
  import row_scan_pkg::*;
#(
  parameter int ROWS = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROWS-1:0]   q,
  input  logic              frame,
  input  logic              blank_n,
  output logic [2*ROWS-1:0] lvl_code
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) lvl_code[2*r +: 2] <= LVL_V5;
      else     lvl_code[2*r +: 2] <= row_level(frame, q[r], blank_n);
    end
  end

  // R9
  blank_all_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> (lvl_code == {(2*ROWS){1'b1}}));
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
  parameter int ROWS = 240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_pulse,
  input  logic              dir_up,
  input  logic              dual_mode,
  input  logic              cas_a_in,
  input  logic              cas_b_in,
  input  logic              aux_in,
  input  logic              frame,
  input  logic              blank_n,
  output logic              cas_a_out,
  output logic              cas_a_oe,
  output logic              cas_b_out,
  output logic              cas_b_oe,
  output logic [2*ROWS-1:0] lvl_code
);
  localparam int HALF = ROWS / 2;

  logic            shift;
  logic [ROWS-1:0] chain_q;
  logic            head_in;
  logic            tail;
  logic            tail_q;

  row_scan_strobe u_strobe (
    .clk        (clk),
    .rst        (rst),
    .line_pulse (line_pulse),
    .shift      (shift)
  );

  assign head_in = dir_up ? cas_a_in : cas_b_in;

  row_scan_chain #(.ROWS(ROWS)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift   (shift),
    .up      (dir_up),
    .dual    (dual_mode),
    .head_in (head_in),
    .aux_in  (aux_in),
    .q       (chain_q)
  );

  row_scan_levels #(.ROWS(ROWS)) u_levels (
    .clk      (clk),
    .rst      (rst),
    .q        (chain_q),
    .frame    (frame),
    .blank_n  (blank_n),
    .lvl_code (lvl_code)
  );

  always_comb begin
    if (!dir_up)        tail = chain_q[0];
    else if (dual_mode) tail = chain_q[HALF-1];
    else                tail = chain_q[ROWS-1];
  end

  always_ff @(posedge clk) begin
    if (rst) tail_q <= 1'b0;
    else     tail_q <= tail;
  end

  assign cas_a_oe  = ~dir_up;
  assign cas_b_oe  = dir_up;
  assign cas_a_out = ~dir_up & tail_q;
  assign cas_b_out = dir_up & tail_q;

  // R3
  single_up_tail_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && dir_up && !dual_mode && $past(dir_up && !dual_mode))
      |-> (cas_b_out == $past(chain_q[ROWS-1])));

  // R4
  down_tail_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !dir_up && $past(!dir_up))
      |-> (cas_a_out == $past(chain_q[0])));

  // R5
  dual_up_tail_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && dir_up && dual_mode && $past(dir_up && dual_mode))
      |-> (cas_b_out == $past(chain_q[HALF-1])));
endmodule

// File: tb/test_row_scan_shifter.sv
module test_row_scan_shifter;
  localparam int R = 8;
  localparam int H = R / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_pulse = 1'b0, dir_up = 1'b1, dual_mode = 1'b0;
  logic cas_a_in = 1'b0, cas_b_in = 1'b0, aux_in = 1'b0;
  logic frame = 1'b0, blank_n = 1'b1;
  logic cas_a_out, cas_a_oe, cas_b_out, cas_b_oe;
  logic [2*R-1:0] lvl_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2*R-1:0] lvl;
    logic ao, aoe, bo, boe;
    string tag;
  } exp_t;

  exp_t sbq[$];
  logic [R-1:0] mdl = '0;

  always #2 clk = ~clk;

  row_scan_shifter #(.ROWS(R)) i_row_scan_shifter (
    .clk(clk), .rst(rst), .line_pulse(line_pulse), .dir_up(dir_up),
    .dual_mode(dual_mode), .cas_a_in(cas_a_in), .cas_b_in(cas_b_in),
    .aux_in(aux_in), .frame(frame), .blank_n(blank_n),
    .cas_a_out(cas_a_out), .cas_a_oe(cas_a_oe), .cas_b_out(cas_b_out),
    .cas_b_oe(cas_b_oe), .lvl_code(lvl_code)
  );

  // R8 / R9 table, written from the requirements
  function automatic logic [1:0] code_of(logic f, logic b, logic on);
    if (!on) return 2'b11;
    if (!f) return b ? 2'b00 : 2'b10;
    return b ? 2'b11 : 2'b01;
  endfunction

  function automatic exp_t mk(string tag);
    exp_t e;
    logic t;
    for (int r = 0; r < R; r++) e.lvl[2*r +: 2] = code_of(frame, mdl[r], blank_n);
    t = !dir_up ? mdl[0] : (dual_mode ? mdl[H-1] : mdl[R-1]);
    e.ao  = !dir_up & t;
    e.bo  = dir_up & t;
    e.aoe = !dir_up;
    e.boe = dir_up;
    e.tag = tag;
    return e;
  endfunction

  task automatic step(logic a, logic b, logic x);
    logic [R-1:0] n;
    for (int i = 0; i < R; i++) begin
      if (dir_up) begin
        if (i == 0)                   n[i] = a;
        else if (dual_mode && i == H) n[i] = x;
        else                          n[i] = mdl[i-1];
      end else begin
        if (i == R-1)                     n[i] = dual_mode ? x : b;
        else if (dual_mode && i == H-1)   n[i] = b;
        else                              n[i] = mdl[i+1];
      end
    end
    mdl = n;
  endtask

  // Monitor: pops one expected item per falling clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (lvl_code !== e.lvl || cas_a_out !== e.ao || cas_b_out !== e.bo ||
            cas_a_oe !== e.aoe || cas_b_oe !== e.boe) begin
          errors++;
          $display("FAIL %s: actual lvl=%h a=%b/%b b=%b/%b expected lvl=%h a=%b/%b b=%b/%b",
                   e.tag, lvl_code, cas_a_out, cas_a_oe, cas_b_out, cas_b_oe,
                   e.lvl, e.ao, e.aoe, e.bo, e.boe);
        end
      end
    end
  end

  task automatic do_reset();
    exp_t e;
    @(negedge clk); #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    e.lvl = '1; e.ao = 1'b0; e.bo = 1'b0;
    e.aoe = !dir_up; e.boe = dir_up; e.tag = "R1 reset state";
    sbq.push_back(e);
    @(negedge clk); #1 rst = 1'b0;
    mdl = '0;
  endtask

  task automatic set_cfg(logic d, logic du, logic f, logic bn, string tag);
    @(negedge clk); #1;
    dir_up = d; dual_mode = du; frame = f; blank_n = bn;
    repeat (2) @(negedge clk);
    #1 sbq.push_back(mk(tag));
  endtask

  task automatic pulse(logic a, logic b, logic x, string tag);
    @(negedge clk); #1;
    cas_a_in = a; cas_b_in = b; aux_in = x; line_pulse = 1'b1;
    @(negedge clk); #1 line_pulse = 1'b0;
    sbq.push_back(mk("R10 old contents on shifting edge"));
    @(negedge clk); #1;
    step(a, b, x);
    cas_a_in = 1'b0; cas_b_in = 1'b0; aux_in = 1'b0;
    sbq.push_back(mk(tag));
  endtask

  task automatic hold_test();
    @(negedge clk); #1;
    cas_a_in = 1'b1; line_pulse = 1'b1;
    repeat (4) @(negedge clk);
    #1 sbq.push_back(mk("R2 line pulse held high"));
    @(negedge clk); #1 line_pulse = 1'b0;
    @(negedge clk); #1;
    step(1'b1, 1'b0, 1'b0);
    cas_a_in = 1'b0;
    sbq.push_back(mk("R2 shift on falling line pulse"));
  endtask

  initial begin
    do_reset();
    // single, upward
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, "R8 empty chain frame 0");
    pulse(1'b1, 1'b0, 1'b0, "R3 token into row 1");
    for (int k = 0; k < R; k++) pulse(1'b0, 1'b0, 1'b0, "R3 token walks up and cascades");
    hold_test();
    pulse(1'b0, 1'b0, 1'b0, "R3 token after hold");
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1, "R8 frame 1 codes");
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, "R9 blank forces 2'b11");
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, "R8 frame 0 codes after unblank");
    // single, downward
    do_reset();
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, "R7 pin A drives when scanning down");
    pulse(1'b0, 1'b1, 1'b0, "R4 token into last row");
    pulse(1'b0, 1'b1, 1'b0, "R4 second token");
    for (int k = 0; k < R; k++) pulse(1'b0, 1'b0, 1'b0, "R4 tokens walk down and cascade");
    // dual, upward
    do_reset();
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1, "R7 pin B drives when scanning up");
    pulse(1'b1, 1'b0, 1'b1, "R5 both halves loaded");
    pulse(1'b0, 1'b0, 1'b0, "R5 halves advance");
    pulse(1'b0, 1'b0, 1'b1, "R5 aux second token");
    for (int k = 0; k < H; k++) pulse(1'b0, 1'b0, 1'b0, "R5 first half cascades at row H");
    set_cfg(1'b1, 1'b1, 1'b1, 1'b1, "R8 frame 1 dual");
    // dual, downward
    do_reset();
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, "R7 dual down pin enables");
    pulse(1'b0, 1'b1, 1'b1, "R6 both halves loaded");
    pulse(1'b0, 1'b0, 1'b0, "R6 halves advance");
    pulse(1'b1, 1'b0, 1'b0, "R6 pin A input ignored scanning down");
    for (int k = 0; k < H; k++) pulse(1'b0, 1'b0, 1'b0, "R6 first half cascades at row 1");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (R1..R10 run): actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule